// File: doc/BRIEF.md
# Test UDP Burst Generator

This block is a test-traffic source for one channel of a multi-channel UDP output path. When an operator presses a push-button, it emits a burst of UDP payloads as a byte stream with valid/ready handshake. Each beat carries start-of-packet and end-of-packet markers, and the packet's payload length is held on a separate field for the whole packet. The block produces payloads only. Header construction, channel multiplexing and transmission happen downstream. One instance drives each test channel.

A DIP-switch input selects one of two burst patterns. The short pattern is fifteen packets whose payloads grow from 2 to 30 bytes in steps of 2. The jumbo pattern is two packets of 8972 bytes each. Every payload byte is a known function of its packet number and byte position, so a receiver can check the content.

The control is a two-state machine. `ST_IDLE` waits for a debounced press. The transition `idle_to_send`, taken on a press, latches the mode and clears the packet and byte counters. `ST_SEND` presents one byte per cycle and advances only when the byte is accepted. Inside `ST_SEND`, three things can happen:
- `next_byte` moves to the next byte of the same packet.
- `next_packet`, taken on the accepted last byte of a packet that is not the final one, moves to the following packet.
- `send_to_idle`, taken on the accepted last byte of the final packet, ends the burst.

The button conditioner is a separate small machine. It synchronises the button, then holds a stable level that changes only after the synchronised input has differed from it for a configurable number of cycles. It emits a single-cycle press pulse when that stable level rises.

Top module: `udp_burst_gen`

## Requirements
- R1: After reset, `m_valid` and `busy` are low, and they stay low until a press is recognised.
- R2: With `mode_jumbo` low at burst start, a burst consists of exactly 15 packets with payload lengths 2, 4, 6, … 30 bytes, in that order.
- R3: With `mode_jumbo` high at burst start, a burst consists of exactly 2 packets, each of `JUMBO_LEN` bytes (default 8972).
- R4: Byte n (counted from 0) of packet k (counted from 0 within the burst) equals (k + n) mod 256.
- R5: `m_sop` is high exactly on byte 0 of each packet, and `m_eop` is high exactly on the last byte. `m_len` equals the payload length of the current packet on every beat of that packet.
- R6: While `m_valid` is high and `m_ready` is low, the next cycle keeps `m_valid` high, and keeps `m_data`, `m_sop`, `m_eop` and `m_len` unchanged.
- R7: A press is recognised only after the button, once synchronised through two flip-flops, has stayed high for `DEBOUNCE_CYCLES` consecutive cycles. A shorter pulse starts no burst.
- R8: A burst starts only on the press edge. Holding the button high after the burst ends starts no second burst.
- R9: A press that arrives while a burst is in progress is ignored. No further packets follow the burst.
- R10: `mode_jumbo` is sampled only when a burst starts. Changing it during a burst does not alter that burst's pattern.
- R11: `busy` is high from the first beat of a burst until the final byte of its last packet has been accepted, and is low in the cycle after that acceptance. `m_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| button_in | input | 1 | Raw push-button level, asynchronous |
| mode_jumbo | input | 1 | Pattern select: 0 = short packets, 1 = jumbo packets |
| m_ready | input | 1 | Downstream accepts the current beat |
| m_valid | output | 1 | A payload byte is presented |
| m_data | output | 8 | Payload byte |
| m_sop | output | 1 | First byte of a packet |
| m_eop | output | 1 | Last byte of a packet |
| m_len | output | 16 | Payload length of the current packet in bytes |
| busy | output | 1 | Burst in progress |

## Verification
The bench builds the block with `DEBOUNCE_CYCLES` = 4 and `JUMBO_LEN` = 40, and leaves the short-pattern parameters at their defaults of 15 packets in steps of 2. The short debounce window lets the bench test glitch rejection and press recognition within a few dozen cycles. The reduced jumbo length lets it run several complete jumbo bursts, under steady and stalling `m_ready`, and check every byte and marker. Bursts run with a press and a mode change injected mid-burst, and with the button held long after the burst ends.

// File: rtl/udpgen_pkg.sv
package udpgen_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } gen_state_t;

    typedef enum logic [0:0] {
        PAT_SHORT = 1'b0,
        PAT_JUMBO = 1'b1
    } pattern_t;

endpackage

// File: rtl/udpgen_debounce.sv
module udpgen_debounce #(
    parameter int DEBOUNCE_CYCLES = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic press
);
    localparam int CNT_W = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic             sync_a;
    logic             sync_b;
    logic             level;
    logic [CNT_W-1:0] cnt;

    // Two-flop synchroniser
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= raw_in;
            sync_b <= sync_a;
        end
    end

    // Stable level changes only after the input differs for the whole window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= 1'b0;
            cnt   <= '0;
            press <= 1'b0;
        end else begin
            press <= 1'b0;
            if (sync_b == level) begin
                cnt <= '0;
            end else if (cnt == CNT_LAST) begin
                cnt   <= '0;
                level <= sync_b;
                press <= sync_b;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R8
    press_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);

    // R7
    press_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        press |-> level);

endmodule

// File: rtl/udpgen_seq.sv
module udpgen_seq
    import udpgen_pkg::*;
#(
    parameter int SHORT_COUNT = 15,
    parameter int SHORT_STEP  = 2,
    parameter int JUMBO_COUNT = 2,
    parameter int JUMBO_LEN   = 8972,
    parameter int LEN_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             mode_in,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [7:0]       m_data,
    output logic             m_sop,
    output logic             m_eop,
    output logic [LEN_W-1:0] m_len,
    output logic             busy
);
    localparam int MAX_PKTS = (SHORT_COUNT > JUMBO_COUNT) ? SHORT_COUNT : JUMBO_COUNT;
    localparam int PKT_W    = $clog2(MAX_PKTS + 1);
    localparam logic [PKT_W-1:0] SHORT_LAST = PKT_W'(SHORT_COUNT - 1);
    localparam logic [PKT_W-1:0] JUMBO_LAST = PKT_W'(JUMBO_COUNT - 1);
    localparam logic [LEN_W-1:0] SHORT_MAX  = LEN_W'(SHORT_COUNT * SHORT_STEP);

    gen_state_t       state;
    pattern_t         pat_q;
    logic [PKT_W-1:0] pkt;
    logic [LEN_W-1:0] idx;
    logic [LEN_W-1:0] cur_len;
    logic             last_byte;
    logic             last_pkt;
    logic             accept;

    // Packet length and end conditions
    always_comb begin
        if (pat_q == PAT_JUMBO) begin
            cur_len  = LEN_W'(JUMBO_LEN);
            last_pkt = (pkt == JUMBO_LAST);
        end else begin
            cur_len  = LEN_W'((32'(pkt) + 32'd1) * 32'(SHORT_STEP));
            last_pkt = (pkt == SHORT_LAST);
        end
        last_byte = (idx == cur_len - 1'b1);
        accept    = (state == ST_SEND) && m_ready;
    end

    // State register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pat_q <= PAT_SHORT;
            pkt   <= '0;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        // idle_to_send
                        state <= ST_SEND;
                        pat_q <= pattern_t'(mode_in);
                        pkt   <= '0;
                        idx   <= '0;
                    end
                end
                ST_SEND: begin
                    if (accept) begin
                        if (!last_byte) begin
                            // next_byte
                            idx <= idx + 1'b1;
                        end else if (!last_pkt) begin
                            // next_packet
                            pkt <= pkt + 1'b1;
                            idx <= '0;
                        end else begin
                            // send_to_idle
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        m_valid = 1'b0;
        m_sop   = 1'b0;
        m_eop   = 1'b0;
        m_data  = 8'h00;
        m_len   = '0;
        busy    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_SEND: begin
                busy    = 1'b1;
                m_valid = 1'b1;
                m_sop   = (idx == '0);
                m_eop   = last_byte;
                m_data  = 8'(pkt) + idx[7:0];
                m_len   = cur_len;
            end
            default: busy = 1'b0;
        endcase
    end

    // R6
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_sop)
                                   && $stable(m_eop) && $stable(m_len)));

    // R5
    sop_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && m_ready && m_eop && busy) |=> (!m_valid || m_sop));

    // R5
    idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> (idx < m_len));

    // R2
    short_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && pat_q == PAT_SHORT) |->
            (m_len != '0 && m_len <= SHORT_MAX && (m_len % LEN_W'(SHORT_STEP)) == '0));

    // R10
    pattern_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pat_q));

endmodule

// File: rtl/udp_burst_gen.sv
module udp_burst_gen #(
    parameter int DEBOUNCE_CYCLES = 250000,
    parameter int SHORT_COUNT     = 15,
    parameter int SHORT_STEP      = 2,
    parameter int JUMBO_COUNT     = 2,
    parameter int JUMBO_LEN       = 8972,
    parameter int LEN_W           = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             button_in,
    input  logic             mode_jumbo,
    input  logic             m_ready,
    output logic             m_valid,
    output logic [7:0]       m_data,
    output logic             m_sop,
    output logic             m_eop,
    output logic [LEN_W-1:0] m_len,
    output logic             busy
);
    logic press;

    udpgen_debounce #(
        .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
    ) u_btn (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_in(button_in),
        .press (press)
    );

    udpgen_seq #(
        .SHORT_COUNT(SHORT_COUNT),
        .SHORT_STEP (SHORT_STEP),
        .JUMBO_COUNT(JUMBO_COUNT),
        .JUMBO_LEN  (JUMBO_LEN),
        .LEN_W      (LEN_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (press),
        .mode_in(mode_jumbo),
        .m_ready(m_ready),
        .m_valid(m_valid),
        .m_data (m_data),
        .m_sop  (m_sop),
        .m_eop  (m_eop),
        .m_len  (m_len),
        .busy   (busy)
    );

    // R11
    valid_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> busy);

endmodule

// File: tb/sim_udp_burst_gen.sv
module sim_udp_burst_gen;
    localparam int DB  = 4;
    localparam int JL  = 40;
    localparam int SC  = 15;
    localparam int SS  = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        button_in = 1'b0;
    logic        mode_jumbo = 1'b0;
    logic        m_ready = 1'b0;
    logic        m_valid;
    logic [7:0]  m_data;
    logic        m_sop;
    logic        m_eop;
    logic [15:0] m_len;
    logic        busy;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    udp_burst_gen #(
        .DEBOUNCE_CYCLES(DB),
        .JUMBO_LEN(JL)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .button_in(button_in), .mode_jumbo(mode_jumbo),
        .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data), .m_sop(m_sop),
        .m_eop(m_eop), .m_len(m_len), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input bit jmb, input int k);
        return jmb ? JL : (k + 1) * SS;
    endfunction

    // Drives one press and collects the resulting burst.
    // rmode: 0 always ready, 1 stall every third cycle, 2 irregular stalls
    task automatic run_burst(input bit jmb, input int rmode, input int hold,
                             input bit toggle_mode, input bit press_mid, input string tag);
        int  pkt = 0, idx = 0, cyc = 0, bad_data = 0, bad_mark = 0, bad_len = 0;
        int  bad_busy = 0, bad_hold = 0, first_busy = -1;
        bit  started = 0, stalled = 0, done = 0;
        int  n_exp = jmb ? 2 : SC;
        logic [7:0]  sd;
        logic [15:0] sl;
        logic ss, se;
        mode_jumbo = jmb;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            button_in = (cyc < hold) || (press_mid && cyc >= 60 && cyc < 80);
            if (toggle_mode && cyc == 30) mode_jumbo = ~mode_jumbo;
            case (rmode)
                0: m_ready = 1'b1;
                1: m_ready = (cyc % 3) != 0;
                default: m_ready = ((cyc * 7) % 5) >= 2;
            endcase
            if (stalled) begin
                if (!m_valid || m_data != sd || m_len != sl || m_sop != ss || m_eop != se)
                    bad_hold++;
            end
            if (m_valid && !busy) bad_busy++;
            if (busy && first_busy < 0) first_busy = cyc;
            if (m_valid) started = 1;
            stalled = m_valid && !m_ready;
            sd = m_data; sl = m_len; ss = m_sop; se = m_eop;
            if (m_valid && m_ready) begin
                if (pkt >= n_exp) begin
                    bad_len++;
                end else begin
                    if (m_data != 8'((pkt + idx) % 256)) bad_data++;
                    if (m_sop != (idx == 0) || m_eop != (idx == exp_len(jmb, pkt) - 1)) bad_mark++;
                    if (m_len != 16'(exp_len(jmb, pkt))) bad_len++;
                    idx++;
                    if (idx == exp_len(jmb, pkt)) begin
                        idx = 0;
                        pkt++;
                    end
                end
            end else if (started && !busy) begin
                done = 1;
            end
            cyc++;
        end
        // R2 / R3: packet count of the burst
        chk(pkt == n_exp && idx == 0, jmb ? "R3 packet count" : "R2 packet count", pkt, n_exp);
        chk(bad_len == 0, jmb ? "R3 length field" : "R2 length field", bad_len, 0);
        // R4
        chk(bad_data == 0, "R4 payload bytes", bad_data, 0);
        // R5
        chk(bad_mark == 0, "R5 sop/eop markers", bad_mark, 0);
        // R6
        chk(bad_hold == 0, "R6 stall hold", bad_hold, 0);
        // R11
        chk(bad_busy == 0 && done, "R11 busy envelope", bad_busy, 0);
        // R7: press must not be recognised before sync + debounce window
        chk(first_busy >= DB, "R7 debounce latency", first_busy, DB);
        if (toggle_mode) chk(pkt == n_exp, "R10 mode change ignored", pkt, n_exp);
        // quiet period: no retrigger while held or by mid-burst press
        begin
            int extra = 0;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (cyc + i >= hold) button_in = 1'b0;
                if (m_valid || busy) extra++;
            end
            if (press_mid) chk(extra == 0, "R9 press during burst ignored", extra, 0);
            else chk(extra == 0, "R8 no retrigger", extra, 0);
        end
        button_in = 1'b0;
        repeat (20) @(negedge clk);
        $display("burst %s done", tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk(!m_valid && !busy, "R1 reset idle", int'(m_valid) + int'(busy), 0);
        end
    endtask

    task automatic t_glitch();
        int seen = 0;
        button_in = 1'b1;
        repeat (2) @(negedge clk);
        button_in = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy || m_valid) seen++;
        end
        chk(seen == 0, "R7 short pulse rejected", seen, 0);
    endtask

    initial begin
        t_reset();
        t_glitch();
        run_burst(1'b0, 0, 20, 1'b0, 1'b0, "short ready");
        run_burst(1'b0, 1, 20, 1'b0, 1'b1, "short stall press_mid");
        run_burst(1'b1, 0, 20, 1'b0, 1'b0, "jumbo ready");
        run_burst(1'b1, 2, 20, 1'b1, 1'b0, "jumbo stall mode toggle");
        run_burst(1'b0, 2, 20, 1'b1, 1'b0, "short mode toggle");
        run_burst(1'b0, 0, 400, 1'b0, 1'b0, "short long hold");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule